// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a free-running 64-bit main counter that arrives as an input. When the counter equals the stored comparator value it sets a level interrupt status, provided the channel's interrupt is enabled. A channel is either 64 bits or 32 bits wide, chosen by a parameter. A 32-bit channel compares only the low half of the counter. Both widths support one-shot operation. The 64-bit channel also supports a periodic mode, in which a separate period register is added to the comparator after every match.

Software reaches the channel through a 32-bit register port with four word addresses. The address is the top two bits of the offset: 0 is control, 1 is status, 2 is the comparator low half and 3 is the comparator high half. Control bit 0 enables the interrupt, bit 1 selects periodic mode and bit 2 is the value-set bit. Status bit 0 is the interrupt level and is cleared by writing 1 to it. A 64-bit comparator is reloaded over the 32-bit port with this sequence: set value-set, write the low half, set value-set again, then write the high half.

Top module: `evt_cmp_channel`

## Requirements
- R1: When the main counter equals the comparator while control bit 0 is 1, status bit 0 reads 1 two clock edges after the counter value is presented, and `irq` follows status bit 0.
- R2: A match while control bit 0 is 0 leaves status bit 0 at 0.
- R3: In one-shot mode (control bit 1 = 0), a match does not change the comparator value.
- R4: A 32-bit channel compares only counter bits 31:0. It therefore matches again when the counter's upper half has changed. Writes to its comparator high half are ignored, and that half reads 0.
- R5: In periodic mode the comparator is increased by the period register after each match, modulo 2^64. For example, FFFFFFFF_FFFF0000h plus a period of 20000h gives 00000000_00010000h.
- R6: After reset the comparator bits that exist read all ones, unimplemented bits read 0, and control and status read 0.
- R7: While control bit 2 is 1, a write to a comparator half updates that half of both the comparator and the period register, and control bit 2 then reads 0.
- R8: In periodic mode with control bit 2 at 0, a write to a comparator half updates only the period register, and the comparator read-back is unchanged.
- R9: On a 32-bit channel control bit 1 cannot be set, and the comparator never advances.
- R10: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. A match in the same cycle takes priority over the clear.
- R11: Reading the comparator halves returns the current value, which in periodic mode is the advanced value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_cnt | input | 64 | Free-running main counter value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 control, 1 status, 2 comparator low, 3 comparator high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| irq | output | 1 | Interrupt level (status bit 0) |

## Verification
The bound assertions check on every cycle the following: a match while enabled sets the status, the comparator stays still in one-shot mode when it is not being written, and each periodic match moves the comparator by exactly the period. They also check that value-set clears after a comparator write, that a 32-bit channel never enters periodic mode or carries upper bits, and that a write-1 clear takes effect. Only the bench scenarios show the end-to-end results. These include the modular wrap from FFFFFFFF_FFFF0000h, the difference between value-set and period-only half writes, the repeated match of a 32-bit channel after the counter's upper half changes, and the read-back of the advanced comparator through the register port.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int REG_W  = 32;
    localparam int CNT_W  = 64;

    localparam int CTL_EN   = 0;
    localparam int CTL_PER  = 1;
    localparam int CTL_VSET = 2;

    typedef enum logic [1:0] {
        ADR_CTRL   = 2'd0,
        ADR_STAT   = 2'd1,
        ADR_CMP_LO = 2'd2,
        ADR_CMP_HI = 2'd3
    } adr_e;

    typedef struct packed {
        logic vset;
        logic periodic;
        logic en;
    } ctl_t;

    function automatic logic [CNT_W-1:0] width_mask(input bit wide);
        return wide ? {CNT_W{1'b1}} : {{(CNT_W-REG_W){1'b0}}, {REG_W{1'b1}}};
    endfunction

endpackage

// File: rtl/evt_ctl_reg.sv
module evt_ctl_reg
    import evt_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  adr_e       addr,
    input  logic [2:0] wbits,
    input  logic       hit,
    output ctl_t       ctl,
    output logic       sts
);

    ctl_t ctl_q;
    logic sts_q;
    logic cmp_wr;

    assign cmp_wr = wr && (addr == ADR_CMP_LO || addr == ADR_CMP_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr && addr == ADR_CTRL) begin
            ctl_q.en       <= wbits[CTL_EN];
            ctl_q.periodic <= WIDE ? wbits[CTL_PER] : 1'b0;
            ctl_q.vset     <= wbits[CTL_VSET];
        end else if (cmp_wr) begin
            ctl_q.vset <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= 1'b0;
        end else if (hit && ctl_q.en) begin
            sts_q <= 1'b1;
        end else if (wr && addr == ADR_STAT && wbits[0]) begin
            sts_q <= 1'b0;
        end
    end

    assign ctl = ctl_q;
    assign sts = sts_q;

endmodule

// File: rtl/evt_cmp_store.sv
module evt_cmp_store
    import evt_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  adr_e             addr,
    input  logic [REG_W-1:0] wdata,
    input  ctl_t             ctl,
    input  logic             hit,
    output logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] per_val
);

    localparam int CW = WIDE ? CNT_W : REG_W;

    logic [CW-1:0]    cmp_q, per_q;
    logic [CNT_W-1:0] cmp_w, per_w;
    logic             lo_wr, hi_wr, take_cmp;

    assign lo_wr    = wr && addr == ADR_CMP_LO;
    assign hi_wr    = wr && addr == ADR_CMP_HI && WIDE;
    assign take_cmp = ctl.vset || !ctl.periodic;

    always_comb begin
        cmp_w = CNT_W'(cmp_q);
        per_w = CNT_W'(per_q);
        if (hit && ctl.periodic) begin
            cmp_w = cmp_w + per_w;
        end
        if (lo_wr) begin
            per_w[REG_W-1:0] = wdata;
            if (take_cmp) cmp_w[REG_W-1:0] = wdata;
        end
        if (hi_wr) begin
            per_w[CNT_W-1:REG_W] = wdata;
            if (take_cmp) cmp_w[CNT_W-1:REG_W] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            cmp_q <= cmp_w[CW-1:0];
            per_q <= per_w[CW-1:0];
        end
    end

    assign cmp_val = CNT_W'(cmp_q);
    assign per_val = CNT_W'(per_q);

endmodule

// File: rtl/evt_match.sv
module evt_match
    import evt_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             hit
);

    localparam logic [CNT_W-1:0] MASK = width_mask(WIDE);

    logic hit_q;

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= ((cnt & MASK) == cmp);
    end

    assign hit = hit_q;

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] main_cnt,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    adr_e             addr;
    ctl_t             ctl;
    logic             sts_q;
    logic             hit_q;
    logic [CNT_W-1:0] cmp_val, per_val;
    logic             ctl_en, ctl_per, ctl_vset;

    assign addr     = adr_e'(reg_addr);
    assign ctl_en   = ctl.en;
    assign ctl_per  = ctl.periodic;
    assign ctl_vset = ctl.vset;

    evt_match #(.WIDE(WIDE)) u_match (
        .clk (clk),
        .rst (rst),
        .cnt (main_cnt),
        .cmp (cmp_val),
        .hit (hit_q)
    );

    evt_ctl_reg #(.WIDE(WIDE)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (addr),
        .wbits (reg_wdata[2:0]),
        .hit   (hit_q),
        .ctl   (ctl),
        .sts   (sts_q)
    );

    evt_cmp_store #(.WIDE(WIDE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (addr),
        .wdata   (reg_wdata),
        .ctl     (ctl),
        .hit     (hit_q),
        .cmp_val (cmp_val),
        .per_val (per_val)
    );

    always_comb begin
        unique case (addr)
            ADR_CTRL:   reg_rdata = {29'd0, ctl_vset, ctl_per, ctl_en};
            ADR_STAT:   reg_rdata = {31'd0, sts_q};
            ADR_CMP_LO: reg_rdata = cmp_val[31:0];
            ADR_CMP_HI: reg_rdata = cmp_val[63:32];
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = sts_q;

endmodule

// File: rtl/evt_cmp_chk.sv
module evt_cmp_chk #(
    parameter bit WIDE = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [63:0] cmp_val,
    input logic [63:0] per_val,
    input logic        hit_q,
    input logic        ctl_en,
    input logic        ctl_per,
    input logic        ctl_vset,
    input logic        sts_q,
    input logic        irq
);

    logic cmp_wr;
    assign cmp_wr = reg_wr && reg_addr[1];

    AST_MATCH_SETS_STS: assert property (@(posedge clk) disable iff (rst)
        (hit_q && ctl_en) |=> sts_q) else $error("match did not set status"); // R1

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        irq == sts_q) else $error("irq differs from status"); // R1

    AST_ONESHOT_STILL: assert property (@(posedge clk) disable iff (rst)
        (!ctl_per && !cmp_wr) |=> $stable(cmp_val)) else $error("one-shot comparator moved"); // R3

    AST_PERIODIC_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl_per && hit_q && !cmp_wr) |=> (cmp_val == $past(cmp_val + per_val)))
        else $error("periodic step wrong"); // R5

    AST_VSET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> !ctl_vset) else $error("value-set not cleared"); // R7

    AST_STS_W1C: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && reg_wdata[0] && !(hit_q && ctl_en)) |=> !sts_q)
        else $error("status not cleared"); // R10

    generate
        if (!WIDE) begin : g_narrow
            AST_NARROW_NO_PER: assert property (@(posedge clk) disable iff (rst)
                !ctl_per && cmp_val[63:32] == 32'd0) else $error("narrow channel state"); // R9
        end
    endgenerate

endmodule

bind evt_cmp_channel evt_cmp_chk #(.WIDE(WIDE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cmp_val   (cmp_val),
    .per_val   (per_val),
    .hit_q     (hit_q),
    .ctl_en    (ctl_en),
    .ctl_per   (ctl_per),
    .ctl_vset  (ctl_vset),
    .sts_q     (sts_q),
    .irq       (irq)
);

// File: tb/evt_cmp_channel_tb_top.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] main_cnt = '0;
    logic        w_wr = 1'b0, n_wr = 1'b0;
    logic [1:0]  w_addr = '0, n_addr = '0;
    logic [31:0] w_wdata = '0, n_wdata = '0;
    logic [31:0] w_rdata, n_rdata;
    logic        w_irq, n_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    evt_cmp_channel #(.WIDE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .main_cnt(main_cnt),
        .reg_wr(w_wr), .reg_addr(w_addr), .reg_wdata(w_wdata),
        .reg_rdata(w_rdata), .irq(w_irq)
    );

    evt_cmp_channel #(.WIDE(1'b0)) dut_n (
        .clk(clk), .rst(rst), .main_cnt(main_cnt),
        .reg_wr(n_wr), .reg_addr(n_addr), .reg_wdata(n_wdata),
        .reg_rdata(n_rdata), .irq(n_irq)
    );

    typedef struct packed {
        logic [63:0] cmp;
        logic [63:0] cnt;
        logic        en;
        logic        exp_sts;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_1234, 64'h0000_0000_0000_1234, 1'b1, 1'b1},
        '{64'hDEAD_BEEF_0000_0010, 64'hDEAD_BEEF_0000_0010, 1'b1, 1'b1},
        '{64'h0000_0001_0000_0000, 64'h0000_0002_0000_0000, 1'b1, 1'b0},
        '{64'h0000_0000_0000_0055, 64'h0000_0000_0000_0055, 1'b0, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit nar, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        if (nar) begin n_wr = 1'b1; n_addr = a; n_wdata = d; end
        else     begin w_wr = 1'b1; w_addr = a; w_wdata = d; end
        @(negedge clk);
        n_wr = 1'b0; w_wr = 1'b0;
    endtask

    task automatic rd(input bit nar, input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        if (nar) n_addr = a; else w_addr = a;
        #1;
        d = nar ? n_rdata : w_rdata;
    endtask

    task automatic rd_cmp(input bit nar, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(nar, 2'd2, lo);
        rd(nar, 2'd3, hi);
        v = {hi, lo};
    endtask

    // counter value held for exactly one clock edge, then back to idle 0
    task automatic present(input logic [63:0] v);
        @(negedge clk);
        main_cnt = v;
        @(negedge clk);
        main_cnt = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R6 reset state
        rd_cmp(1'b0, v);  chk("R6 wide comparator reset", v, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(1'b0, 2'd0, d); chk("R6 control reset", 64'(d), 64'd0);
        rd(1'b0, 2'd1, d); chk("R6 status reset", 64'(d), 64'd0);
        rd_cmp(1'b1, v);  chk("R6 narrow comparator reset", v, 64'h0000_0000_FFFF_FFFF);

        // table walk: one-shot matches R1 R2 R3 R11
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, 2'd0, {31'd0, VECS[i].en});
            wr(1'b0, 2'd2, VECS[i].cmp[31:0]);
            wr(1'b0, 2'd3, VECS[i].cmp[63:32]);
            wr(1'b0, 2'd1, 32'd1);
            present(VECS[i].cnt);
            rd(1'b0, 2'd1, d);
            chk(VECS[i].en ? "R1 status after match" : "R2 status while disabled",
                64'(d[0]), 64'(VECS[i].exp_sts));
            chk("R1 irq level", 64'(w_irq), 64'(VECS[i].exp_sts));
            rd_cmp(1'b0, v);
            chk("R3 one-shot comparator unchanged", v, VECS[i].cmp);
        end

        // R10 status clear semantics (status is 1 from the last vector)
        wr(1'b0, 2'd1, 32'd0);
        rd(1'b0, 2'd1, d); chk("R10 write 0 keeps status", 64'(d[0]), 64'd1);
        wr(1'b0, 2'd1, 32'd1);
        rd(1'b0, 2'd1, d); chk("R10 write 1 clears status", 64'(d[0]), 64'd0);

        // periodic reinit: value-set, low, value-set, high
        wr(1'b0, 2'd0, 32'h7);
        wr(1'b0, 2'd2, 32'hFFFF_0000);
        rd(1'b0, 2'd0, d); chk("R7 value-set self clears", 64'(d), 64'h3);
        wr(1'b0, 2'd0, 32'h7);
        wr(1'b0, 2'd3, 32'hFFFF_FFFF);
        wr(1'b0, 2'd2, 32'h0002_0000);
        wr(1'b0, 2'd3, 32'h0000_0000);
        rd_cmp(1'b0, v);
        chk("R8 period-only writes leave comparator", v, 64'hFFFF_FFFF_FFFF_0000);
        present(64'hFFFF_FFFF_FFFF_0000);
        rd(1'b0, 2'd1, d); chk("R1 periodic match status", 64'(d[0]), 64'd1);
        rd_cmp(1'b0, v);
        chk("R5 R11 wrapped advance", v, 64'h0000_0000_0001_0000);
        wr(1'b0, 2'd1, 32'd1);
        present(64'h0000_0000_0001_0000);
        rd_cmp(1'b0, v);
        chk("R5 second advance", v, 64'h0000_0000_0003_0000);

        // R7: value-set write also loads the period
        wr(1'b0, 2'd0, 32'h7);
        wr(1'b0, 2'd2, 32'h0000_0040);
        rd_cmp(1'b0, v); chk("R7 comparator loaded", v, 64'h0000_0000_0000_0040);
        present(64'h0000_0000_0000_0040);
        rd_cmp(1'b0, v); chk("R7 period loaded by same write", v, 64'h0000_0000_0000_0080);

        // narrow channel R9 R4
        wr(1'b1, 2'd0, 32'h3);
        rd(1'b1, 2'd0, d); chk("R9 narrow periodic bit ignored", 64'(d), 64'h1);
        wr(1'b1, 2'd2, 32'h0000_0100);
        wr(1'b1, 2'd3, 32'h0000_1234);
        rd_cmp(1'b1, v); chk("R4 narrow high write ignored", v, 64'h0000_0000_0000_0100);
        present(64'h0000_0005_0000_0100);
        rd(1'b1, 2'd1, d); chk("R4 narrow low-half match", 64'(d[0]), 64'd1);
        rd_cmp(1'b1, v); chk("R9 narrow comparator no advance", v, 64'h0000_0000_0000_0100);
        wr(1'b1, 2'd1, 32'd1);
        rd(1'b1, 2'd1, d); chk("R10 narrow clear", 64'(d[0]), 64'd0);
        present(64'h0000_0009_0000_0100);
        rd(1'b1, 2'd1, d); chk("R4 narrow rematch after wrap", 64'(d[0]), 64'd1);
        chk("R1 narrow irq", 64'(n_irq), 64'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule